// File: doc/BRIEF.md
# Temperature Compensation Cycle Scheduler

This block decides when the oscillator's temperature-correction cycle runs. It keeps an 8-bit control register with three parts: a master enable in bit 7, a two-bit battery-mode field in bits 6:5, and a five-bit factory trim value in bits 4:0. The trim value is fixed at build time and software cannot change it. Cycles are launched in two ways: a periodic timer counted in 1 Hz ticks, or a write to the control register with the enable set. Each cycle is a start/done handshake with an external temperature conversion unit.

When a conversion completes, the block compares the reported temperature code with the code from the previous conversion. It captures the externally computed coarse and fine correction values into its trim output registers only when the two codes differ. A single pulse marks each such load. A launch request that arrives while a conversion is still outstanding is held as one pending request. That request starts as soon as the outstanding conversion completes.

Top module: `tcs_sched`

## Requirements
- R1: After reset, `rd_data` reads {0, 00, FACTORY_TRIM}, `conv_start` and `trim_load` are 0, and `coarse_q`/`fine_q` are 0.
- R2: After a write, `rd_data[7:5]` returns the written bits 7:5. `rd_data[4:0]` always returns FACTORY_TRIM (default 5'd19), whatever value was written to bits 4:0.
- R3: On main supply (`on_battery`=0) with the enable set, a cycle starts on the 60th tick after the last launch, whatever the battery-mode field holds.
- R4: A write with bit 7 = 1 while no conversion is outstanding raises `conv_start` in the next cycle and restarts the tick count at zero.
- R5: On battery (`on_battery`=1), bits 6:5 select the tick period: 00 means no timed cycles, 01 means 600 ticks, 10 means 6000 ticks, and 11 means 60 ticks.
- R6: With bit 7 = 0, no cycle is started, whether by the timer or by a write.
- R7: A launch request (a write with bit 7 = 1, or timer expiry) made while a conversion is outstanding is kept as one pending request. `conv_start` then rises in the cycle after `conv_done` is accepted. A write with bit 7 = 0 discards a pending request.
- R8: When `conv_done` is accepted, `coarse_q`/`fine_q` take `coarse_in`/`fine_in` and `trim_load` pulses for one cycle only if `conv_temp` differs from the code of the previous conversion. Otherwise both trim outputs hold their values.
- R9: The first conversion completed after reset always loads the trim outputs.
- R10: `conv_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read-back |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| on_battery | input | 1 | 1 when running from backup battery |
| conv_start | output | 1 | Pulse requesting a temperature conversion |
| conv_done | input | 1 | Pulse marking conversion complete |
| conv_temp | input | TEMP_W | Temperature code of the finished conversion |
| coarse_in | input | COARSE_W | Coarse correction value computed outside |
| fine_in | input | FINE_W | Fine correction value computed outside |
| coarse_q | output | COARSE_W | Coarse trim output register |
| fine_q | output | FINE_W | Fine trim output register |
| trim_load | output | 1 | Pulse when the trim outputs were loaded |

## Verification
The assertions assume that `conv_done` pulses for one cycle, and only after a `conv_start`, so that at most one conversion is outstanding and a done never arrives in the same cycle as its start. They also assume that `tick_1hz` is a one-cycle pulse. The stimulus drives every input on the falling clock edge. Done is raised only by a task that first waits for a start. Ticks are always separated by an idle cycle. Random trials draw the control value, temperature and correction data from `$urandom`, but always finish each conversion before the next launch.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   localparam int CTRL_W   = 8;
   localparam int EN_BIT   = 7;
   localparam int MODE_LSB = 5;
   localparam int FTRIM_W  = 5;

   typedef enum logic [1:0] {
      BAT_NONE    = 2'b00,
      BAT_SLOW_A  = 2'b01,
      BAT_SLOW_B  = 2'b10,
      BAT_FAST    = 2'b11
   } bat_mode_e;
endpackage

// File: rtl/tcs_period_timer.sv
module tcs_period_timer
   import tcs_pkg::*;
#(
   parameter int MAIN_SECS   = 60,
   parameter int BAT_A_SECS  = 600,
   parameter int BAT_B_SECS  = 6000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      restart,
   input  logic      enable,
   input  logic      on_battery,
   input  bat_mode_e mode,
   output logic      due
);
   localparam int MAX_AB = (BAT_A_SECS > BAT_B_SECS) ? BAT_A_SECS : BAT_B_SECS;
   localparam int MAX_P  = (MAX_AB > MAIN_SECS) ? MAX_AB : MAIN_SECS;
   localparam int CNT_W  = $clog2(MAX_P);

   if (MAIN_SECS < 2 || BAT_A_SECS < 2 || BAT_B_SECS < 2) begin : g_bad_period
      $error("tcs_period_timer: every period must be at least two ticks");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             active;

   always_comb begin
      active = enable;
      last   = CNT_W'(MAIN_SECS - 1);
      if (on_battery) begin
         unique case (mode)
            BAT_NONE:   active = 1'b0;
            BAT_SLOW_A: last   = CNT_W'(BAT_A_SECS - 1);
            BAT_SLOW_B: last   = CNT_W'(BAT_B_SECS - 1);
            BAT_FAST:   last   = CNT_W'(MAIN_SECS - 1);
            default:    active = 1'b0;
         endcase
      end
   end

   assign due = tick && active && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || !active)
         cnt <= '0;
      else if (tick)
         cnt <= due ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/tcs_launch_ctrl.sv
module tcs_launch_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic write_go,
   input  logic write_stop,
   input  logic timer_due,
   input  logic conv_done,
   output logic launch,
   output logic conv_start,
   output logic busy,
   output logic pending
);
   logic req;

   assign req    = write_go || timer_due;
   assign launch = busy ? (conv_done && (pending || req)) : req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_start <= 1'b0;
         busy       <= 1'b0;
         pending    <= 1'b0;
      end else begin
         conv_start <= launch;
         if (launch) begin
            busy    <= 1'b1;
            pending <= 1'b0;
         end else if (busy && conv_done) begin
            busy    <= 1'b0;
            pending <= 1'b0;
         end else if (busy) begin
            pending <= write_stop ? 1'b0 : (pending || req);
         end
      end
   end
endmodule

// File: rtl/tcs_trim_latch.sv
module tcs_trim_latch #(
   parameter int TEMP_W   = 10,
   parameter int COARSE_W = 6,
   parameter int FINE_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic [TEMP_W-1:0]   temp,
   input  logic [COARSE_W-1:0] coarse_in,
   input  logic [FINE_W-1:0]   fine_in,
   output logic [COARSE_W-1:0] coarse_q,
   output logic [FINE_W-1:0]   fine_q,
   output logic                loaded,
   output logic                prev_valid
);
   localparam int OUT_W = COARSE_W + FINE_W;

   if (TEMP_W < 1 || COARSE_W < 1 || FINE_W < 1) begin : g_bad_width
      $error("tcs_trim_latch: widths must be positive");
   end

   logic [TEMP_W-1:0] prev_temp;
   logic [OUT_W-1:0]  trim_q;
   logic              changed;

   assign changed = !prev_valid || (temp != prev_temp);
   assign coarse_q = trim_q[OUT_W-1:FINE_W];
   assign fine_q   = trim_q[FINE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_temp  <= '0;
         prev_valid <= 1'b0;
         trim_q     <= '0;
         loaded     <= 1'b0;
      end else begin
         loaded <= accept && changed;
         if (accept) begin
            prev_temp  <= temp;
            prev_valid <= 1'b1;
            if (changed)
               trim_q <= {coarse_in, fine_in};
         end
      end
   end
endmodule

// File: rtl/tcs_sched.sv
module tcs_sched
   import tcs_pkg::*;
#(
   parameter int                  TEMP_W       = 10,
   parameter int                  COARSE_W     = 6,
   parameter int                  FINE_W       = 3,
   parameter int                  MAIN_SECS    = 60,
   parameter int                  BAT_A_SECS   = 600,
   parameter int                  BAT_B_SECS   = 6000,
   parameter logic [FTRIM_W-1:0]  FACTORY_TRIM = 5'd19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   output logic [CTRL_W-1:0]   rd_data,
   input  logic                tick_1hz,
   input  logic                on_battery,
   output logic                conv_start,
   input  logic                conv_done,
   input  logic [TEMP_W-1:0]   conv_temp,
   input  logic [COARSE_W-1:0] coarse_in,
   input  logic [FINE_W-1:0]   fine_in,
   output logic [COARSE_W-1:0] coarse_q,
   output logic [FINE_W-1:0]   fine_q,
   output logic                trim_load
);
   logic      en_q;
   bat_mode_e mode_q;
   logic      write_go;
   logic      write_stop;
   logic      timer_due;
   logic      launch;
   logic      busy;
   logic      pending;
   logic      prev_valid;

   assign write_go   = wr_en && wr_data[EN_BIT];
   assign write_stop = wr_en && !wr_data[EN_BIT];
   assign rd_data    = {en_q, mode_q, FACTORY_TRIM};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= BAT_NONE;
      end else if (wr_en) begin
         en_q   <= wr_data[EN_BIT];
         mode_q <= bat_mode_e'(wr_data[MODE_LSB +: 2]);
      end
   end

   tcs_period_timer #(
      .MAIN_SECS (MAIN_SECS),
      .BAT_A_SECS(BAT_A_SECS),
      .BAT_B_SECS(BAT_B_SECS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_1hz),
      .restart   (launch || wr_en),
      .enable    (en_q),
      .on_battery(on_battery),
      .mode      (mode_q),
      .due       (timer_due)
   );

   tcs_launch_ctrl u_launch (
      .clk       (clk),
      .rst_n     (rst_n),
      .write_go  (write_go),
      .write_stop(write_stop),
      .timer_due (timer_due),
      .conv_done (conv_done),
      .launch    (launch),
      .conv_start(conv_start),
      .busy      (busy),
      .pending   (pending)
   );

   tcs_trim_latch #(
      .TEMP_W  (TEMP_W),
      .COARSE_W(COARSE_W),
      .FINE_W  (FINE_W)
   ) u_trim (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (conv_done && busy),
      .temp      (conv_temp),
      .coarse_in (coarse_in),
      .fine_in   (fine_in),
      .coarse_q  (coarse_q),
      .fine_q    (fine_q),
      .loaded    (trim_load),
      .prev_valid(prev_valid)
   );
endmodule

// File: rtl/tcs_sched_chk.sv
module tcs_sched_chk #(
   parameter int COARSE_W = 6,
   parameter int FINE_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [7:0]          wr_data,
   input logic [7:0]          rd_data,
   input logic                conv_start,
   input logic                conv_done,
   input logic                busy,
   input logic                pending,
   input logic                prev_valid,
   input logic                trim_load,
   input logic [COARSE_W-1:0] coarse_q,
   input logic [FINE_W-1:0]   fine_q
);
   p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[7:5] == $past(wr_data[7:5]));

   p_write_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[7] && !busy |=> conv_start);

   p_start_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> rd_data[7]);

   p_pending_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && conv_done && pending |=> conv_start);

   p_trim_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({coarse_q, fine_q}) |-> trim_load);

   p_first_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && conv_done && !prev_valid |=> trim_load);

   p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
endmodule

bind tcs_sched tcs_sched_chk #(
   .COARSE_W(COARSE_W),
   .FINE_W  (FINE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .conv_start(conv_start),
   .conv_done (conv_done),
   .busy      (busy),
   .pending   (pending),
   .prev_valid(prev_valid),
   .trim_load (trim_load),
   .coarse_q  (coarse_q),
   .fine_q    (fine_q)
);

// File: tb/tcs_sched_test.sv
module tcs_sched_test;
   localparam int TW = 10, CW = 6, FW = 3;
   localparam logic [4:0] FT = 5'd19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic          tick_1hz = 1'b0;
   logic          on_battery = 1'b0;
   logic          conv_start;
   logic          conv_done = 1'b0;
   logic [TW-1:0] conv_temp = '0;
   logic [CW-1:0] coarse_in = '0;
   logic [FW-1:0] fine_in = '0;
   logic [CW-1:0] coarse_q;
   logic [FW-1:0] fine_q;
   logic          trim_load;

   int checks = 0, errors = 0, starts = 0;
   logic          m_valid = 1'b0;
   logic [TW-1:0] m_prev = '0;
   logic [CW-1:0] m_coarse = '0;
   logic [FW-1:0] m_fine = '0;

   always #10 clk = ~clk;

   tcs_sched uut (.*);

   always @(negedge clk) if (conv_start) starts++;

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic exp_load(logic v, logic [TW-1:0] p, logic [TW-1:0] t);
      return !v || (p != t);
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] d);
      return {d[7:5], FT};
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; #1;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_1hz = 1'b1;
         @(negedge clk); tick_1hz = 1'b0;
      end
      #1;
   endtask

   task automatic finish_conv(logic [TW-1:0] t, logic [CW-1:0] c, logic [FW-1:0] f, string req);
      logic ld;
      ld = exp_load(m_valid, m_prev, t);
      @(negedge clk); conv_done = 1'b1; conv_temp = t; coarse_in = c; fine_in = f;
      @(negedge clk); conv_done = 1'b0; #1;
      if (ld) begin m_coarse = c; m_fine = f; end
      m_valid = 1'b1; m_prev = t;
      chk({req, " trim_load"}, trim_load, ld);
      chk({req, " coarse"}, coarse_q, m_coarse);
      chk({req, " fine"}, fine_q, m_fine);
   endtask

   task automatic period_test(logic [7:0] d, int n, string req);
      int s;
      wr(d);
      finish_conv(m_prev, 6'h2A, 3'h5, req);
      s = starts;
      ticks(n - 1);
      chk({req, " before period"}, starts, s);
      ticks(1);
      chk({req, " at period"}, starts, s + 1);
      finish_conv(m_prev, 6'h11, 3'h1, req);
   endtask

   initial begin
      int s;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 rd_data", rd_data, {3'b000, FT});
      chk("R1 conv_start", conv_start, 0);
      chk("R1 trim_load", trim_load, 0);
      chk("R1 coarse", coarse_q, 0);
      rst_n = 1'b1;

      // R2 and R6: writes with enable clear
      for (int i = 0; i < 6; i++) begin
         logic [7:0] d;
         d = 8'($urandom()) & 8'h7F;
         s = starts;
         wr(d);
         chk("R2 read-back", rd_data, exp_rd(d));
         chk("R6 no start on disabled write", starts, s);
      end

      // R4 write launch, R10 pulse, R9 first load
      s = starts;
      wr(8'h9F);
      chk("R4 start after write", conv_start, 1);
      chk("R2 trim bits fixed", rd_data, exp_rd(8'h9F));
      @(negedge clk); #1;
      chk("R10 single pulse", conv_start, 0);
      chk("R4 one start", starts, s + 1);
      finish_conv(10'h155, 6'h3C, 3'h6, "R9 first load");

      // R8 same temperature keeps trims, new temperature loads
      wr(8'h80);
      finish_conv(10'h155, 6'h01, 3'h1, "R8 same temp");
      wr(8'h80);
      finish_conv(10'h156, 6'h07, 3'h2, "R8 new temp");

      // R3 main supply, mode bits ignored
      period_test(8'h80, 60, "R3 main");
      period_test(8'hA0, 60, "R3 main mode01");

      // R5 battery modes
      on_battery = 1'b1;
      wr(8'h80);
      finish_conv(m_prev, 6'h0, 3'h0, "R5 none");
      s = starts;
      ticks(700);
      chk("R5 mode00 no timed start", starts, s);
      period_test(8'hE0, 60, "R5 mode11");
      period_test(8'hA0, 600, "R5 mode01");
      period_test(8'hC0, 6000, "R5 mode10");
      on_battery = 1'b0;

      // R6 disabled timer
      wr(8'h00);
      s = starts;
      ticks(200);
      chk("R6 no timed start", starts, s);

      // R7 pending request
      wr(8'h80);
      s = starts;
      wr(8'h80);
      chk("R7 held while busy", starts, s);
      finish_conv(m_prev + 1'b1, 6'h15, 3'h3, "R7 done");
      chk("R7 pending start", starts, s + 1);
      finish_conv(m_prev, 6'h16, 3'h4, "R7 second done");
      // R7 pending discarded by disabling write
      wr(8'h80);
      s = starts;
      wr(8'h80);
      wr(8'h00);
      finish_conv(m_prev, 6'h17, 3'h5, "R7 cancel done");
      @(negedge clk); #1;
      chk("R7 pending discarded", starts, s);

      // random trials
      for (int i = 0; i < 40; i++) begin
         logic [7:0] d;
         d = 8'($urandom()) | 8'h80;
         s = starts;
         wr(d);
         chk("R2 random read-back", rd_data, exp_rd(d));
         chk("R4 random launch", starts, s + 1);
         finish_conv(TW'($urandom_range(0, 3)), CW'($urandom()), FW'($urandom()), "R8 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule